// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a serial slave that a command sequencer sits behind. It watches a clock line and a data line with a system clock several times faster than the bus clock. It recognises the framing conditions and gathers incoming bits into bytes, most significant bit first. It also answers or withholds the ninth-clock acknowledge, and it shifts read data back out through an output-enable. The bus has no address phase: the first byte after a start is taken to be the command, and the block flags it so.

The sequencer sees a strobe for each framing event and each completed byte. It steers the block with three level inputs. One decides whether the current byte is acknowledged. One decides whether the next byte flows from the slave to the master. One reports that a nonvolatile write is in progress. While that last input is high, and while the slave is itself driving the data line, framing conditions on the bus are not honoured. When the master declines a read byte, the slave lets go of the line and waits for a stop.

Top module: `tws_slave`

## Requirements
- R1: After reset the data output is released (sdaOe low), no strobe is raised, and bus clocks seen before any start produce neither a byte nor an acknowledge.
- R2: A falling data edge while the bus clock is high is a start: startSeen pulses for one cycle and the next completed byte carries firstByte high; later bytes of the same transaction carry it low.
- R3: Data bits are taken on rising bus-clock edges, MSB first; after the 8th rising edge byteValid pulses for exactly one cycle with byteData holding the byte. byteValid, startSeen, stopSeen and rdAckValid never overlap.
- R4: If ackEn is high at the falling edge that ends the 8th bit, the slave drives SDA low (sdaOe high, sdaOut low) for the whole ninth clock. Otherwise it leaves SDA released, and it ignores further bits until the next start.
- R5: If readMode is high when an acknowledged ninth clock ends, the slave loads txData and drives it MSB first with sdaOe high for eight clocks. Its output changes only after falling bus-clock edges.
- R6: On the ninth rising edge of a read byte, rdAckValid pulses with rdAckOk set when the master held SDA low. An acknowledge starts the next byte from txData. A no-acknowledge releases SDA and ignores starts until a stop arrives.
- R7: A start during byte reception discards the partial byte, and the following byte is again treated as the command byte.
- R8: A rising data edge while the bus clock is high is a stop: stopSeen pulses, SDA is released and the slave returns to standby, ignoring bits until a new start.
- R9: While the slave drives SDA, start and stop patterns are ignored and the byte being sent continues unchanged.
- R10: While writeBusy is high, start and stop patterns are ignored; once it falls, a start is honoured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOut | output | 1 | Value driven onto the data line when enabled |
| sdaOe | output | 1 | Data line output enable |
| writeBusy | input | 1 | Nonvolatile write in progress; blocks start and stop |
| ackEn | input | 1 | Acknowledge the byte now being received |
| readMode | input | 1 | Next byte is sent from the slave to the master |
| txData | input | DATA_W | Byte to transmit, loaded at the start of each read byte |
| startSeen | output | 1 | One-cycle strobe on an honoured start |
| stopSeen | output | 1 | One-cycle strobe on an honoured stop |
| byteValid | output | 1 | One-cycle strobe when a received byte is complete |
| byteData | output | DATA_W | Received byte, valid with byteValid |
| firstByte | output | 1 | The completed byte is the first after a start |
| rdAckValid | output | 1 | One-cycle strobe when the master's ninth bit is sampled |
| rdAckOk | output | 1 | The master acknowledged the read byte |

## Verification
Some properties hold on every cycle, and the assertions cover them. The strobes are single-cycle and mutually exclusive. No start or stop is reported in the cycle after the slave drove SDA or after writeBusy was high. SDA is released whenever a stop or a master-acknowledge sample is reported. The slave's drive does not move while the bus clock has been high for several cycles. The bench's scenarios have to show the rest. They cover the byte values recovered across all 256 codes and the acknowledge choice in the ninth slot. They also cover a start cutting a byte short, and read data flowing until a declined byte. The wait for a stop after that byte, and a framing glitch injected into the middle of a transmitted byte, are exercised as well.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_NAK,
    ST_TX,
    ST_RACK,
    ST_HOLD
  } twsState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;
    logic load;
    logic shiftIn;
    logic shiftOut;
  } dpCtl_t;

  // datapath -> control events
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startCond;
    logic stopCond;
    logic sdaBit;
    logic cntLast;
    logic cntFull;
  } busEv_t;

endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] txData,
  input  dpCtl_t            ctl,
  output busEv_t            ev,
  output logic [DATA_W-1:0] shReg
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;

  // synchronizer chain, depth chosen by parameter
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else begin
          sclPipe[g] <= sclIn;
          sdaPipe[g] <= sdaIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else begin
          sclPipe[g] <= sclPipe[g-1];
          sdaPipe[g] <= sdaPipe[g-1];
        end
      end
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  always_comb begin
    ev.sclRise   = sclS & ~sclQ;
    ev.sclFall   = ~sclS & sclQ;
    ev.startCond = sclS & sclQ & sdaQ & ~sdaS;
    ev.stopCond  = sclS & sclQ & ~sdaQ & sdaS;
    ev.sdaBit    = sdaS;
    ev.cntLast   = (bitCnt == CNT_W'(DATA_W - 1));
    ev.cntFull   = (bitCnt == CNT_W'(DATA_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (ctl.clear) begin
      bitCnt <= '0;
    end else if (ctl.load) begin
      shReg  <= txData;
      bitCnt <= '0;
    end else if (ctl.shiftIn) begin
      shReg  <= {shReg[DATA_W-2:0], sdaS};
      bitCnt <= bitCnt + 1'b1;
    end else if (ctl.shiftOut) begin
      shReg  <= {shReg[DATA_W-2:0], 1'b0};
      bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  busEv_t ev,
  input  logic   shMsb,
  input  logic   writeBusy,
  input  logic   ackEn,
  input  logic   readMode,
  output dpCtl_t ctl,
  output logic   sdaOut,
  output logic   sdaOe,
  output logic   startSeen,
  output logic   stopSeen,
  output logic   byteValid,
  output logic   firstByte,
  output logic   rdAckValid,
  output logic   rdAckOk
);

  twsState_t state, nxt;
  logic driving, startOk, stopOk, firstFlag, mAckFlag;

  assign driving = (state == ST_TX) || (state == ST_ACK);
  assign startOk = ev.startCond & ~driving & ~writeBusy & (state != ST_HOLD);
  assign stopOk  = ev.stopCond & ~driving & ~writeBusy;

  always_comb begin
    nxt = state;
    ctl = '0;
    if (stopOk) begin
      nxt = ST_IDLE;
    end else if (startOk) begin
      nxt       = ST_RX;
      ctl.clear = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (ev.sclRise)                   ctl.shiftIn = 1'b1;
          else if (ev.sclFall && ev.cntFull) nxt = ackEn ? ST_ACK : ST_NAK;
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            if (readMode) begin
              nxt      = ST_TX;
              ctl.load = 1'b1;
            end else begin
              nxt       = ST_RX;
              ctl.clear = 1'b1;
            end
          end
        end
        ST_NAK: if (ev.sclFall) nxt = ST_IDLE;
        ST_TX: begin
          if (ev.sclFall) begin
            if (ev.cntLast) nxt = ST_RACK;
            else            ctl.shiftOut = 1'b1;
          end
        end
        ST_RACK: begin
          if (ev.sclFall) begin
            if (mAckFlag && readMode) begin
              nxt      = ST_TX;
              ctl.load = 1'b1;
            end else if (mAckFlag) begin
              nxt       = ST_RX;
              ctl.clear = 1'b1;
            end else begin
              nxt = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      startSeen  <= 1'b0;
      stopSeen   <= 1'b0;
      byteValid  <= 1'b0;
      rdAckValid <= 1'b0;
      rdAckOk    <= 1'b0;
      mAckFlag   <= 1'b0;
      firstFlag  <= 1'b0;
    end else begin
      state      <= nxt;
      startSeen  <= startOk;
      stopSeen   <= stopOk;
      byteValid  <= (state == ST_RX) & ev.sclRise & ev.cntLast;
      rdAckValid <= (state == ST_RACK) & ev.sclRise;
      if ((state == ST_RACK) && ev.sclRise) begin
        rdAckOk  <= ~ev.sdaBit;
        mAckFlag <= ~ev.sdaBit;
      end
      if (startOk)
        firstFlag <= 1'b1;
      else if (((state == ST_ACK) || (state == ST_NAK)) && ev.sclFall)
        firstFlag <= 1'b0;
    end
  end

  assign sdaOe     = driving;
  assign sdaOut    = (state == ST_TX) ? shMsb : 1'b0;
  assign firstByte = firstFlag;

endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  input  logic              writeBusy,
  input  logic              ackEn,
  input  logic              readMode,
  input  logic [DATA_W-1:0] txData,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData,
  output logic              firstByte,
  output logic              rdAckValid,
  output logic              rdAckOk
);

  dpCtl_t            ctl;
  busEv_t            ev;
  logic [DATA_W-1:0] shReg;

  tws_datapath #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .txData(txData),
    .ctl   (ctl),
    .ev    (ev),
    .shReg (shReg)
  );

  tws_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ev        (ev),
    .shMsb     (shReg[DATA_W-1]),
    .writeBusy (writeBusy),
    .ackEn     (ackEn),
    .readMode  (readMode),
    .ctl       (ctl),
    .sdaOut    (sdaOut),
    .sdaOe     (sdaOe),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .byteValid (byteValid),
    .firstByte (firstByte),
    .rdAckValid(rdAckValid),
    .rdAckOk   (rdAckOk)
  );

  assign byteData = shReg;

endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOut,
  input logic sdaOe,
  input logic writeBusy,
  input logic startSeen,
  input logic stopSeen,
  input logic byteValid,
  input logic rdAckValid
);

  a_r3_byte_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startSeen, stopSeen, byteValid, rdAckValid}));

  a_r5_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn, 1) && $past(sclIn, 2) && $past(sclIn, 3) && $past(sclIn, 4))
      |-> ($stable(sdaOe) && $stable(sdaOut)));

  a_r6_rdack_released: assert property (@(posedge clk) disable iff (!rstN)
    rdAckValid |-> !sdaOe);

  a_r8_stop_released: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |-> !sdaOe);

  a_r9_no_frame_while_driving: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |=> (!startSeen && !stopSeen));

  a_r10_no_frame_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    writeBusy |=> (!startSeen && !stopSeen));

endmodule

bind tws_slave tws_slave_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaOut    (sdaOut),
  .sdaOe     (sdaOe),
  .writeBusy (writeBusy),
  .startSeen (startSeen),
  .stopSeen  (stopSeen),
  .byteValid (byteValid),
  .rdAckValid(rdAckValid)
);

// File: tb/tws_slave_tb.sv
module tws_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int LIMIT      = 190000;
  localparam int NREAD      = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic sclM = 1'b1, sdaM = 1'b1, forceLine = 1'b0;
  logic writeBusy = 1'b0, ackEn = 1'b0, readMode = 1'b0;
  logic [7:0] txData = 8'h00;
  logic sdaOut, sdaOe, startSeen, stopSeen, byteValid, firstByte, rdAckValid, rdAckOk;
  logic [7:0] byteData;
  logic sdaLine;

  assign sdaLine = forceLine ? sdaM : (sdaOe ? sdaOut : sdaM);

  tws_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .writeBusy(writeBusy), .ackEn(ackEn),
    .readMode(readMode), .txData(txData), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteValid(byteValid), .byteData(byteData), .firstByte(firstByte),
    .rdAckValid(rdAckValid), .rdAckOk(rdAckOk)
  );

  int nRun = 0, nFail = 0, cyc = 0;
  int startCnt = 0, stopCnt = 0, byteCnt = 0, rdAckCnt = 0;
  logic [7:0] lastByte = 8'h00;
  logic lastFirst = 1'b0, lastRdOk = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (startSeen) startCnt++;
    if (stopSeen) stopCnt++;
    if (byteValid) begin
      byteCnt++;
      lastByte  = byteData;
      lastFirst = firstByte;
    end
    if (rdAckValid) begin
      rdAckCnt++;
      lastRdOk = rdAckOk;
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > LIMIT) begin
      nFail++;
      $display("FAIL R1 watchdog: actual %0d expected below %0d cycles", cyc, LIMIT);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; idle(HALF);
    sclM = 1'b1; idle(HALF);
    sdaM = 1'b0; idle(HALF);
    sclM = 1'b0; idle(2);
  endtask

  task automatic busStop;
    sdaM = 1'b0; idle(HALF);
    sclM = 1'b1; idle(HALF);
    sdaM = 1'b1; idle(HALF);
  endtask

  task automatic clockBit(input logic b, output logic seen, output logic oe);
    sdaM = b; idle(HALF);
    sclM = 1'b1; idle(HALF / 2);
    seen = sdaLine;
    oe   = sdaOe;
    idle(HALF - HALF / 2);
    sclM = 1'b0; idle(2);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic s, o;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s, o);
    clockBit(1'b1, s, o);
    acked = o && !s;
  endtask

  task automatic readByte(input logic mAck, input logic [7:0] nextTx, input bit glitch,
                          output logic [7:0] v, output logic allOe);
    allOe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; idle(HALF);
      sclM = 1'b1; idle(2);
      v[i]  = sdaLine;
      allOe = allOe & sdaOe;
      if (glitch && i == 4) begin
        forceLine = 1'b1;
        sdaM = 1'b1; idle(3);
        sdaM = 1'b0; idle(3);
        sdaM = 1'b1; idle(HALF - 8);
        forceLine = 1'b0;
      end else begin
        idle(HALF - 2);
      end
      sclM = 1'b0; idle(2);
    end
    txData = nextTx;
    sdaM = !mAck; idle(HALF);
    sclM = 1'b1; idle(HALF);
    sclM = 1'b0; idle(2);
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  initial begin
    logic ack, oe;
    logic [7:0] v;
    int s0, p0, b0, r0;

    idle(5);
    rstN = 1'b1;
    idle(5);
    // R1: reset state
    chk(sdaOe == 1'b0, "R1 released after reset", sdaOe, 0);
    chk(startCnt + stopCnt + byteCnt + rdAckCnt == 0, "R1 no strobes", startCnt + stopCnt + byteCnt, 0);

    // R1: bits with no start are ignored
    ackEn = 1'b1;
    sclM = 1'b0; idle(HALF);
    writeByte(8'hC3, ack);
    chk(byteCnt == 0, "R1 no byte before start", byteCnt, 0);
    chk(ack == 1'b0, "R1 no ack before start", ack, 0);
    busStop;

    // R2 R3 R4: full sweep of byte values in one write transaction
    s0 = startCnt;
    busStart;
    chk(startCnt == s0 + 1, "R2 start strobe", startCnt, s0 + 1);
    for (int val = 0; val < 256; val++) begin
      b0 = byteCnt;
      writeByte(8'(val), ack);
      chk(byteCnt == b0 + 1 && lastByte == 8'(val), "R3 byte value", lastByte, val);
      chk(ack == 1'b1, "R4 ack driven", ack, 1);
      chk(lastFirst == (val == 0), "R2 first byte flag", lastFirst, (val == 0));
    end
    p0 = stopCnt;
    busStop;
    chk(stopCnt == p0 + 1, "R8 stop strobe", stopCnt, p0 + 1);
    chk(sdaOe == 1'b0, "R8 released after stop", sdaOe, 0);

    // R4: no-ack then standby
    ackEn = 1'b0;
    busStart;
    b0 = byteCnt;
    writeByte(8'h81, ack);
    chk(ack == 1'b0, "R4 nack leaves SDA released", ack, 0);
    chk(byteCnt == b0 + 1, "R4 refused byte still reported", byteCnt, b0 + 1);
    ackEn = 1'b1;
    b0 = byteCnt;
    writeByte(8'h42, ack);
    chk(byteCnt == b0 && ack == 1'b0, "R4 ignored after nack", byteCnt, b0);
    busStop;

    // R8: stop returns to standby
    busStart;
    writeByte(8'h11, ack);
    p0 = stopCnt;
    busStop;
    chk(stopCnt == p0 + 1, "R8 stop mid transaction", stopCnt, p0 + 1);
    sclM = 1'b0; idle(HALF);
    b0 = byteCnt;
    writeByte(8'h22, ack);
    chk(byteCnt == b0 && ack == 1'b0, "R8 bits ignored after stop", byteCnt, b0);
    busStop;

    // R7: start aborts a partial byte
    s0 = startCnt;
    busStart;
    writeByte(8'h01, ack);
    clockBit(1'b1, ack, oe); clockBit(1'b0, ack, oe);
    clockBit(1'b1, ack, oe); clockBit(1'b1, ack, oe);
    b0 = byteCnt;
    busStart;
    writeByte(8'h5A, ack);
    chk(startCnt == s0 + 2, "R7 restart strobe", startCnt, s0 + 2);
    chk(byteCnt == b0 + 1 && lastByte == 8'h5A, "R7 partial byte dropped", lastByte, 8'h5A);
    chk(lastFirst == 1'b1, "R7 command byte again", lastFirst, 1);
    busStop;

    // R5 R6 R9: read stream, glitch on one byte, no-ack on last
    busStart;
    readMode = 1'b1;
    txData = pat(0);
    writeByte(8'h80, ack);
    chk(ack == 1'b1, "R5 command acked", ack, 1);
    for (int k = 0; k < NREAD; k++) begin
      s0 = startCnt; p0 = stopCnt; r0 = rdAckCnt;
      readByte(k < NREAD - 1, pat(k + 1), k == 5, v, oe);
      chk(v == pat(k), "R5 read data", v, pat(k));
      chk(oe == 1'b1, "R5 driven all bits", oe, 1);
      chk(rdAckCnt == r0 + 1 && lastRdOk == (k < NREAD - 1), "R6 master ack sample",
          lastRdOk, (k < NREAD - 1));
      if (k == 5)
        chk(startCnt == s0 && stopCnt == p0, "R9 framing ignored while driving",
            startCnt + stopCnt, s0 + p0);
    end
    readMode = 1'b0;
    chk(sdaOe == 1'b0, "R6 released after nack", sdaOe, 0);
    s0 = startCnt;
    busStart;
    chk(startCnt == s0, "R6 start ignored awaiting stop", startCnt, s0);
    p0 = stopCnt;
    busStop;
    chk(stopCnt == p0 + 1, "R6 stop accepted after nack", stopCnt, p0 + 1);

    // R10: write busy blocks framing
    writeBusy = 1'b1;
    s0 = startCnt; p0 = stopCnt; b0 = byteCnt;
    busStart;
    writeByte(8'h33, ack);
    chk(startCnt == s0, "R10 start ignored when busy", startCnt, s0);
    chk(byteCnt == b0 && ack == 1'b0, "R10 no byte when busy", byteCnt, b0);
    busStop;
    chk(stopCnt == p0, "R10 stop ignored when busy", stopCnt, p0);
    writeBusy = 1'b0;
    idle(4);
    busStart;
    chk(startCnt == s0 + 1, "R10 start honoured after busy", startCnt, s0 + 1);
    busStop;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule